// File: doc/BRIEF.md
# Processor bus strobe and buffer control

This purely combinational block sits between an 8-bit processor and the system buses. The processor offers raw active-low memory-request, I/O-request, read and write strobes. From these the block forms four qualified active-low strobes for the system: memory read, memory write, port input and port output. It also steers a bidirectional data-bus transceiver through a pair of active-low direction enables. The direction follows the raw read strobe alone, not the qualified strobes.

An active-low takeover input, `takeover_n`, lets an external bus master own the buses. An external pull-up keeps it inactive when it is left open. While it is low, the address outputs and the four qualified strobes float, and the transceiver is forced into the direction toward the processor. A separate, always-driven flag reports the illegal case in which both request strobes are low at once. In that case every qualified strobe is held inactive.

Top module: `bus_strobe_ctrl`

## Requirements
- R1: While `takeover_n` is 1 and no request conflict exists, `mem_rd_n` is 0 exactly when `cpu_mreq_n` is 0 and `cpu_rd_n` is 0; otherwise it is 1.
- R2: While `takeover_n` is 1 and no request conflict exists, `mem_wr_n` is 0 exactly when `cpu_mreq_n` is 0 and `cpu_wr_n` is 0; otherwise it is 1.
- R3: While `takeover_n` is 1 and no request conflict exists, `io_rd_n` is 0 exactly when `cpu_iorq_n` is 0 and `cpu_rd_n` is 0; otherwise it is 1.
- R4: While `takeover_n` is 1 and no request conflict exists, `io_wr_n` is 0 exactly when `cpu_iorq_n` is 0 and `cpu_wr_n` is 0; otherwise it is 1.
- R5: While `takeover_n` is 1, `cpu_rd_n` = 1 gives `dbuf_out_en_n` = 0 and `dbuf_in_en_n` = 1, and `cpu_rd_n` = 0 gives `dbuf_out_en_n` = 1 and `dbuf_in_en_n` = 0. The request and write strobes have no effect on these two outputs.
- R6: While `takeover_n` is 0, `dbuf_out_en_n` is 1 and `dbuf_in_en_n` is 0, whatever the other inputs are.
- R7: While `takeover_n` is 0, `bus_addr` and the four qualified strobes are high-impedance, so a pull-up reads them as all ones. While `takeover_n` is 1, `bus_addr` equals `cpu_addr`.
- R8: `dbuf_out_en_n` and `dbuf_in_en_n` are never 0 at the same time.
- R9: A request conflict exists when `cpu_mreq_n` and `cpu_iorq_n` are both 0. During a conflict `req_conflict` is 1 and, while `takeover_n` is 1, all four qualified strobes are 1. Otherwise `req_conflict` is 0. `takeover_n` does not affect `req_conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| takeover_n | input | 1 | Active-low external-master takeover |
| cpu_mreq_n | input | 1 | Processor memory request, active low |
| cpu_iorq_n | input | 1 | Processor I/O request, active low |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_addr | input | ADDR_W | Processor address |
| bus_addr | output | ADDR_W | Buffered system address, floats on takeover |
| mem_rd_n | output | 1 | Qualified memory read, floats on takeover |
| mem_wr_n | output | 1 | Qualified memory write, floats on takeover |
| io_rd_n | output | 1 | Qualified port input, floats on takeover |
| io_wr_n | output | 1 | Qualified port output, floats on takeover |
| dbuf_out_en_n | output | 1 | Transceiver processor-to-bus enable, active low |
| dbuf_in_en_n | output | 1 | Transceiver bus-to-processor enable, active low |
| req_conflict | output | 1 | Both request strobes asserted together |

## Verification
Two functions can act in the same cycle: the takeover override and the processor strobe decode. One example is a memory read driven while `takeover_n` is low. The bench sweeps all 32 combinations of the five control inputs under several address patterns. For each one it computes the expected pulled-up strobe levels, the address and the transceiver enables. It then judges whether the override wins: strobes that would otherwise be driven low must read high through the pull-up, and the transceiver must face the processor. The same sweep covers the case where both requests are low. There the conflict flag must rise whether or not the override is active.

// File: rtl/bus_strobe_ctrl.sv
module bus_strobe_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              takeover_n,
  input  logic              cpu_mreq_n,
  input  logic              cpu_iorq_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              dbuf_out_en_n,
  output logic              dbuf_in_en_n,
  output logic              req_conflict
);

  logic       drive;
  logic       mem_sel, io_sel;
  logic [3:0] strb_n;
  logic       toward_cpu;

  assign drive        = takeover_n;
  assign req_conflict = ~cpu_mreq_n & ~cpu_iorq_n;
  assign mem_sel      = ~cpu_mreq_n & ~req_conflict;
  assign io_sel       = ~cpu_iorq_n & ~req_conflict;

  // order: memory read, memory write, port input, port output
  assign strb_n[0] = ~(mem_sel & ~cpu_rd_n);
  assign strb_n[1] = ~(mem_sel & ~cpu_wr_n);
  assign strb_n[2] = ~(io_sel  & ~cpu_rd_n);
  assign strb_n[3] = ~(io_sel  & ~cpu_wr_n);

  assign toward_cpu    = ~cpu_rd_n | ~takeover_n;
  assign dbuf_out_en_n = toward_cpu;
  assign dbuf_in_en_n  = ~toward_cpu;

  assign bus_addr = drive ? cpu_addr  : {ADDR_W{1'bz}};
  assign mem_rd_n = drive ? strb_n[0] : 1'bz;
  assign mem_wr_n = drive ? strb_n[1] : 1'bz;
  assign io_rd_n  = drive ? strb_n[2] : 1'bz;
  assign io_wr_n  = drive ? strb_n[3] : 1'bz;

  always_comb begin
    assert_one_space_R1: assert (!(~strb_n[0] | ~strb_n[1]) || !cpu_mreq_n)
      else $error("memory strobe without memory request");
    assert_one_space_R3: assert (!(~strb_n[2] | ~strb_n[3]) || !cpu_iorq_n)
      else $error("port strobe without I/O request");
    assert_single_strobe_R2: assert ($countones(~strb_n) <= 2)
      else $error("too many qualified strobes");
    assert_dir_write_R5: assert (!(takeover_n && cpu_rd_n) || !dbuf_out_en_n)
      else $error("transceiver not driving toward bus");
    assert_dir_forced_R6: assert (takeover_n || !dbuf_in_en_n)
      else $error("takeover did not force input direction");
    assert_no_contention_R8: assert (dbuf_out_en_n || dbuf_in_en_n)
      else $error("both transceiver enables active");
    assert_conflict_quiet_R9: assert (!req_conflict || (&strb_n))
      else $error("strobe issued during request conflict");
    assert_rw_pair_R4: assert (!(~strb_n[1] | ~strb_n[3]) || !cpu_wr_n)
      else $error("write strobe without processor write");
  end

endmodule

// File: tb/bus_strobe_ctrl_test.sv
module bus_strobe_ctrl_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          takeover_n, cpu_mreq_n, cpu_iorq_n, cpu_rd_n, cpu_wr_n;
  logic [AW-1:0] cpu_addr;
  wire  [AW-1:0] bus_addr;
  wire           mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic          dbuf_out_en_n, dbuf_in_en_n, req_conflict;

  pullup (mem_rd_n);
  pullup (mem_wr_n);
  pullup (io_rd_n);
  pullup (io_wr_n);
  for (genvar g = 0; g < AW; g++) begin : g_pu
    pullup (bus_addr[g]);
  end

  bus_strobe_ctrl #(.ADDR_W(AW)) uut (
    .takeover_n(takeover_n), .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_addr(cpu_addr),
    .bus_addr(bus_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .dbuf_out_en_n(dbuf_out_en_n),
    .dbuf_in_en_n(dbuf_in_en_n), .req_conflict(req_conflict)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'h1234; pats[2] = 16'hA5C3; pats[3] = 16'h7FFE;

    takeover_n = 1'b1; cpu_mreq_n = 1'b1; cpu_iorq_n = 1'b1;
    cpu_rd_n = 1'b1; cpu_wr_n = 1'b1; cpu_addr = '0;
    @(negedge clk); #1;
    // idle state: nothing asserted, transceiver drives toward bus
    check({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R1 idle strobes",
          AW'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 16'hF);
    check(dbuf_out_en_n == 1'b0 && dbuf_in_en_n == 1'b1, "R5 idle direction",
          AW'({dbuf_out_en_n, dbuf_in_en_n}), 16'h1);
    check(req_conflict == 1'b0, "R9 idle flag", AW'(req_conflict), 16'h0);

    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 32; v++) begin
        logic t, m, i, r, w, conf, live, dirin;
        logic e_mr, e_mw, e_ir, e_iw;
        logic [AW-1:0] e_addr;
        @(negedge clk);
        {t, m, i, r, w} = v[4:0];
        takeover_n = t; cpu_mreq_n = m; cpu_iorq_n = i;
        cpu_rd_n = r; cpu_wr_n = w; cpu_addr = pats[p];
        #1;
        conf  = !m && !i;
        live  = t && !conf;
        e_mr  = !(live && !m && !r);
        e_mw  = !(live && !m && !w);
        e_ir  = !(live && !i && !r);
        e_iw  = !(live && !i && !w);
        dirin = !r || !t;
        e_addr = t ? pats[p] : {AW{1'b1}};
        check(mem_rd_n === e_mr, "R1 memory read", AW'(mem_rd_n), AW'(e_mr));
        check(mem_wr_n === e_mw, "R2 memory write", AW'(mem_wr_n), AW'(e_mw));
        check(io_rd_n  === e_ir, "R3 port input", AW'(io_rd_n), AW'(e_ir));
        check(io_wr_n  === e_iw, "R4 port output", AW'(io_wr_n), AW'(e_iw));
        if (t)
          check(dbuf_out_en_n === dirin && dbuf_in_en_n === !dirin, "R5 direction follows read",
                AW'({dbuf_out_en_n, dbuf_in_en_n}), AW'({dirin, !dirin}));
        else
          check(dbuf_out_en_n === 1'b1 && dbuf_in_en_n === 1'b0, "R6 forced input direction",
                AW'({dbuf_out_en_n, dbuf_in_en_n}), 16'h2);
        // R7: floating address reads as all ones through the pull-ups
        check(bus_addr === e_addr, "R7 address buffer", bus_addr, e_addr);
        check(!(dbuf_out_en_n === 1'b0 && dbuf_in_en_n === 1'b0), "R8 no contention",
              AW'({dbuf_out_en_n, dbuf_in_en_n}), 16'h1);
        check(req_conflict === conf, "R9 conflict flag", AW'(req_conflict), AW'(conf));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule